// File: doc/BRIEF.md
# Interleaved Single-Error-Correcting Memory Word Codec

This block protects one physical memory row that holds eight independent data words. On the write side each 137-bit word is expanded into a 146-bit codeword with a Hamming-style single-error-correcting code. The eight codewords are then spread across the row so that physically adjacent cells always belong to different words. A defect that spans up to eight neighbouring cells therefore costs each word at most one bit, and the code can repair that bit.

On the read side the block gathers each word's bits back out of the row and computes a 9-bit syndrome per word. If the syndrome names a bit position that exists in the codeword, that bit is inverted. Otherwise the raw data is passed on and the word is flagged as uncorrectable. Decoded data, flags and syndromes are registered, so they appear one clock after the row is presented.

The code corrects single errors only and does not detect double errors. It is meant to sit beside spare-row and spare-column repair, not to replace it.

Top module: `intlv_ecc_codec`

## Requirements
- R1: Within each 146-bit codeword, positions are numbered 1 to 146. Check bits occupy positions 1, 2, 4, 8, 16, 32, 64 and 128. Data bits 0 to 136 fill the remaining positions 3 to 145 in ascending order. Position 146 holds a ninth check bit that the encoder always writes as 0. Check bit 2^i is the even parity of all positions 1 to 145 whose index has bit i set.
- R2: Bit at position p (1-based) of lane k is placed at physical row bit (p-1)*8+k. Lane k write data is `wr_data_i[k*137 +: 137]`.
- R3: A row read with no flipped bits returns the written data for every lane, with syndrome 0 and both flags low.
- R4: A single flipped bit at codeword position p in 1 to 145 of any lane gives that lane a syndrome equal to p. Corrected is high, uncorrectable is low, and the original data is returned.
- R5: A flipped bit at position 146 gives syndrome 256 (bit 8 set). Corrected is high, and the data is returned unchanged.
- R6: A syndrome in 146 to 255 or 257 to 511 raises uncorrectable and leaves corrected low. The lane's data bits are then passed on exactly as read, with no bit inverted.
- R7: Decoded data, flags and syndromes change on the first rising clock edge after the row is presented, and not before.
- R8: While `rst_ni` is low, all read outputs are 0.
- R9: Lanes decode independently. One error in each of the eight lanes in the same read, including eight adjacent physical bits, is corrected in all lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | 1096 | Eight 137-bit write words, lane k at bits k*137 upward |
| wr_word_o | output | 1168 | Interleaved encoded row (combinational) |
| rd_word_i | input | 1168 | Physical row read from the array |
| rd_data_o | output | 1096 | Decoded data per lane, registered |
| rd_corr_o | output | 8 | Per-lane single-bit correction applied |
| rd_uncorr_o | output | 8 | Per-lane syndrome names no existing position |
| rd_synd_o | output | 72 | Per-lane 9-bit syndrome, lane k at bits k*9 upward |

## Verification
A wrong parity equation or a wrong data placement in the encoder appears at once on `wr_word_o`, in the same cycle the data is presented. A wrong interleave map on the read side, or an off-by-one in the correction index, appears one clock later: the syndrome names the wrong position, or a lane's data differs in the bit that should have been repaired. Sweeping a single flipped bit through every codeword position, spread over all eight lanes, exposes any position whose syndrome column or correction is wrong. Errors aimed at the ninth check bit and out-of-range syndromes separate the correct, spare and uncorrectable branches.

// File: rtl/intlv_ecc_pkg.sv
package intlv_ecc_pkg;
  localparam int DATA_W_DEF = 137;
  localparam int CHK_W_DEF  = 9;
  localparam int LANES_DEF  = 8;

  function automatic bit is_pow2(int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction
endpackage

// File: rtl/intlv_ecc_enc.sv
module intlv_ecc_enc
  import intlv_ecc_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int CHK_W  = CHK_W_DEF,
  localparam int CW_W  = DATA_W + CHK_W,
  localparam int HAM_W = CW_W - 1
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);
  logic [CHK_W-1:0] acc;

  always_comb begin
    int d;
    d    = 0;
    acc  = '0;
    cw_o = '0;
    for (int p = 1; p <= HAM_W; p++) begin
      if (!is_pow2(p)) begin
        cw_o[p-1] = data_i[d];
        if (data_i[d]) acc ^= CHK_W'(p);
        d++;
      end
    end
    for (int i = 0; i < CHK_W - 1; i++) cw_o[(1 << i) - 1] = acc[i];
    // spare check column: covers only itself, written as zero
    cw_o[CW_W-1] = 1'b0;
  end
endmodule

// File: rtl/intlv_ecc_dec.sv
module intlv_ecc_dec
  import intlv_ecc_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int CHK_W  = CHK_W_DEF,
  localparam int CW_W  = DATA_W + CHK_W,
  localparam int HAM_W = CW_W - 1
) (
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  synd_o,
  output logic              corr_o,
  output logic              uncorr_o
);
  localparam logic [CHK_W-1:0] SPARE_SYN = CHK_W'(1) << (CHK_W - 1);
  localparam logic [CHK_W-1:0] LAST_POS  = CHK_W'(HAM_W);

  logic [CW_W-1:0] fixed;

  always_comb begin
    synd_o = '0;
    for (int p = 1; p <= HAM_W; p++) if (cw_i[p-1]) synd_o ^= CHK_W'(p);
    if (cw_i[CW_W-1]) synd_o ^= SPARE_SYN;
  end

  assign corr_o   = (synd_o != '0) && ((synd_o <= LAST_POS) || (synd_o == SPARE_SYN));
  assign uncorr_o = (synd_o != '0) && !corr_o;

  always_comb begin
    for (int p = 1; p <= HAM_W; p++)
      fixed[p-1] = cw_i[p-1] ^ (corr_o && (synd_o == CHK_W'(p)));
    fixed[CW_W-1] = cw_i[CW_W-1] ^ (synd_o == SPARE_SYN);
  end

  always_comb begin
    int d;
    d      = 0;
    data_o = '0;
    for (int p = 1; p <= HAM_W; p++) begin
      if (!is_pow2(p)) begin
        data_o[d] = fixed[p-1];
        d++;
      end
    end
  end
endmodule

// File: rtl/intlv_ecc_codec.sv
module intlv_ecc_codec
  import intlv_ecc_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int CHK_W  = CHK_W_DEF,
  parameter int LANES  = LANES_DEF,
  localparam int CW_W  = DATA_W + CHK_W,
  localparam int ROW_W = CW_W * LANES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [LANES*DATA_W-1:0] wr_data_i,
  output logic [ROW_W-1:0]        wr_word_o,
  input  logic [ROW_W-1:0]        rd_word_i,
  output logic [LANES*DATA_W-1:0] rd_data_o,
  output logic [LANES-1:0]        rd_corr_o,
  output logic [LANES-1:0]        rd_uncorr_o,
  output logic [LANES*CHK_W-1:0]  rd_synd_o
);
  logic [CW_W-1:0]   enc_cw [LANES];
  logic [CW_W-1:0]   rd_cw  [LANES];
  logic [DATA_W-1:0] dec_data [LANES];
  logic [CHK_W-1:0]  dec_synd [LANES];
  logic [LANES-1:0]  dec_corr, dec_uncorr;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    intlv_ecc_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_enc (
      .data_i (wr_data_i[k*DATA_W +: DATA_W]),
      .cw_o   (enc_cw[k])
    );
    intlv_ecc_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_dec (
      .cw_i     (rd_cw[k]),
      .data_o   (dec_data[k]),
      .synd_o   (dec_synd[k]),
      .corr_o   (dec_corr[k]),
      .uncorr_o (dec_uncorr[k])
    );
  end

  // bit j of lane k <-> row bit j*LANES+k
  always_comb begin
    for (int k = 0; k < LANES; k++)
      for (int j = 0; j < CW_W; j++) begin
        wr_word_o[j*LANES+k] = enc_cw[k][j];
        rd_cw[k][j]          = rd_word_i[j*LANES+k];
      end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o   <= '0;
      rd_corr_o   <= '0;
      rd_uncorr_o <= '0;
      rd_synd_o   <= '0;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        rd_data_o[k*DATA_W +: DATA_W] <= dec_data[k];
        rd_synd_o[k*CHK_W +: CHK_W]   <= dec_synd[k];
      end
      rd_corr_o   <= dec_corr;
      rd_uncorr_o <= dec_uncorr;
    end
  end
endmodule

module intlv_ecc_codec_chk #(
  parameter int DATA_W = 137,
  parameter int CHK_W  = 9,
  parameter int LANES  = 8,
  localparam int CW_W  = DATA_W + CHK_W,
  localparam int ROW_W = CW_W * LANES
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [LANES*DATA_W-1:0] wr_data_i,
  input logic [ROW_W-1:0]        wr_word_o,
  input logic [ROW_W-1:0]        rd_word_i,
  input logic [LANES*DATA_W-1:0] rd_data_o,
  input logic [LANES-1:0]        rd_corr_o,
  input logic [LANES-1:0]        rd_uncorr_o,
  input logic [LANES*CHK_W-1:0]  rd_synd_o
);
  localparam logic [CHK_W-1:0] SPARE_SYN = CHK_W'(1) << (CHK_W - 1);
  localparam logic [CHK_W-1:0] LAST_POS  = CHK_W'(CW_W - 1);

  logic [1:0] cyc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    logic [CW_W-1:0]   wcw;
    logic [DATA_W-1:0] w_data;
    logic [CHK_W-1:0]  w_synd, syn;
    logic              w_corr, w_unc;

    always_comb for (int j = 0; j < CW_W; j++) wcw[j] = wr_word_o[j*LANES+k];
    assign syn = rd_synd_o[k*CHK_W +: CHK_W];

    intlv_ecc_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_wchk (
      .cw_i (wcw), .data_o (w_data), .synd_o (w_synd),
      .corr_o (w_corr), .uncorr_o (w_unc)
    );

    // R1 / R2: encoded row decodes clean back to the write data
    a_r1_enc_roundtrip: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (w_synd == '0) && !w_corr && !w_unc && (w_data == wr_data_i[k*DATA_W +: DATA_W]));

    a_r3_zero_syn_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (syn == '0) |-> (!rd_corr_o[k] && !rd_uncorr_o[k]));

    a_r4_corr_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_corr_o[k] |-> ((syn != '0) && ((syn <= LAST_POS) || (syn == SPARE_SYN)) && !rd_uncorr_o[k]));

    a_r6_uncorr_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_uncorr_o[k] |-> ((syn > LAST_POS) && (syn != SPARE_SYN)));
  end

  a_r7_one_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cyc >= 2'd2) && $stable(rd_word_i)) |=>
      ($stable(rd_data_o) && $stable(rd_corr_o) && $stable(rd_uncorr_o) && $stable(rd_synd_o)));
endmodule

bind intlv_ecc_codec intlv_ecc_codec_chk #(
  .DATA_W(DATA_W), .CHK_W(CHK_W), .LANES(LANES)
) u_chk (.*);

// File: tb/intlv_ecc_codec_tb.sv
`timescale 1ns/1ps
module intlv_ecc_codec_tb;
  localparam int DW = 137;
  localparam int SW = 9;
  localparam int CW = DW + SW;
  localparam int NL = 8;
  localparam int PW = CW * NL;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic [NL*DW-1:0] wr_data_i;
  logic [PW-1:0]    wr_word_o, rd_word_i;
  logic [NL*DW-1:0] rd_data_o;
  logic [NL-1:0]    rd_corr_o, rd_uncorr_o;
  logic [NL*SW-1:0] rd_synd_o;

  always #5 clk_i = ~clk_i;

  intlv_ecc_codec u_dut (
    .clk_i, .rst_ni, .wr_data_i, .wr_word_o, .rd_word_i,
    .rd_data_o, .rd_corr_o, .rd_uncorr_o, .rd_synd_o
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input string what,
                     input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [NL*DW-1:0] data;
    logic [NL-1:0]    corr;
    logic [NL-1:0]    unc;
    logic [NL*SW-1:0] syn;
    string            tag;
  } exp_t;
  exp_t sb[$];

  function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int idx;
    c = '0; idx = 0;
    for (int p = 1; p <= CW - 1; p++)
      if ((p & (p - 1)) != 0) begin c[p-1] = d[idx]; idx++; end
    for (int i = 0; i < SW - 1; i++) begin
      logic par;
      par = 1'b0;
      for (int p = 1; p <= CW - 1; p++) if ((p & (1 << i)) != 0) par ^= c[p-1];
      c[(1 << i) - 1] = par;
    end
    return c;
  endfunction

  function automatic logic [DW-1:0] ref_data(input logic [CW-1:0] c);
    logic [DW-1:0] d;
    int idx;
    d = '0; idx = 0;
    for (int p = 1; p <= CW - 1; p++)
      if ((p & (p - 1)) != 0) begin d[idx] = c[p-1]; idx++; end
    return d;
  endfunction

  function automatic logic [PW-1:0] to_row(input logic [NL-1:0][CW-1:0] c);
    logic [PW-1:0] w;
    for (int k = 0; k < NL; k++)
      for (int j = 0; j < CW; j++) w[j*NL+k] = c[k][j];
    return w;
  endfunction

  function automatic logic [NL-1:0][DW-1:0] mk_data(input int seed);
    logic [NL-1:0][DW-1:0] d;
    for (int k = 0; k < NL; k++)
      for (int i = 0; i < DW; i++)
        d[k][i] = (((i * seed + k * 13 + (i >> 2)) % 7) < 3);
    return d;
  endfunction

  function automatic int row_bit(input int lane, input int pos);
    return (pos - 1) * NL + lane;
  endfunction

  function automatic exp_t mk_exp(input logic [NL-1:0][DW-1:0] d, input logic [NL-1:0] c,
                                  input logic [NL-1:0] u, input logic [NL-1:0][SW-1:0] s,
                                  input string tag);
    exp_t e;
    e.data = d; e.corr = c; e.unc = u; e.syn = s; e.tag = tag;
    return e;
  endfunction

  task automatic drive_rd(input logic [PW-1:0] w, input exp_t e);
    @(negedge clk_i);
    rd_word_i = w;
    sb.push_back(e);
  endtask

  // monitor: results appear one edge after the row is presented (R7)
  initial begin
    forever begin
      exp_t e;
      @(posedge clk_i);
      #1;
      if (rst_ni && sb.size() > 0) begin
        e = sb.pop_front();
        chk(e.tag, "data (R7 timing)", PW'(rd_data_o), PW'(e.data));
        chk(e.tag, "corrected", PW'(rd_corr_o), PW'(e.corr));
        chk(e.tag, "uncorrectable", PW'(rd_uncorr_o), PW'(e.unc));
        chk(e.tag, "syndrome", PW'(rd_synd_o), PW'(e.syn));
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [NL-1:0][DW-1:0] dat, exd;
    logic [NL-1:0][CW-1:0] cws;
    logic [PW-1:0]         row, bad;
    logic [NL-1:0][SW-1:0] syn;
    int                    seeds [3] = '{0, 5, 11};

    rst_ni    = 1'b0;
    wr_data_i = '0;
    rd_word_i = {PW{1'b1}};
    repeat (3) @(negedge clk_i);
    // R8: reset holds outputs at zero even with a non-zero row present
    chk("R8", "rd_data_o in reset", PW'(rd_data_o), '0);
    chk("R8", "flags in reset", PW'({rd_corr_o, rd_uncorr_o}), '0);
    chk("R8", "syndrome in reset", PW'(rd_synd_o), '0);
    rst_ni    = 1'b1;
    rd_word_i = '0;
    @(negedge clk_i);

    // R1, R2: encoder output for several data patterns
    foreach (seeds[s]) begin
      dat = (s == 0) ? '1 : mk_data(seeds[s]);
      for (int k = 0; k < NL; k++) cws[k] = ref_enc(dat[k]);
      wr_data_i = dat;
      #1;
      for (int k = 0; k < NL; k++) begin
        logic [CW-1:0] got;
        for (int j = 0; j < CW; j++) got[j] = wr_word_o[j*NL+k];
        chk("R1", $sformatf("lane %0d codeword", k), PW'(got), PW'(cws[k]));
      end
      chk("R2", "interleaved row", wr_word_o, to_row(cws));
      @(negedge clk_i);
    end

    // R3: clean reads
    foreach (seeds[s]) begin
      dat = mk_data(seeds[s] + 2);
      for (int k = 0; k < NL; k++) cws[k] = ref_enc(dat[k]);
      drive_rd(to_row(cws), mk_exp(dat, '0, '0, '0, "R3"));
    end

    // R4: single flip swept through positions 1..145, lanes rotating
    dat = mk_data(7);
    for (int k = 0; k < NL; k++) cws[k] = ref_enc(dat[k]);
    row = to_row(cws);
    for (int p = 1; p <= CW - 1; p++) begin
      int ln;
      ln  = p % NL;
      bad = row;
      bad[row_bit(ln, p)] = ~bad[row_bit(ln, p)];
      syn = '0; syn[ln] = SW'(p);
      drive_rd(bad, mk_exp(dat, NL'(1) << ln, '0, syn, "R4"));
    end

    // R7: output not updated before the edge
    drive_rd(row, mk_exp(dat, '0, '0, '0, "R7"));
    bad = row; bad[row_bit(4, 9)] = ~bad[row_bit(4, 9)];
    syn = '0; syn[4] = SW'(9);
    drive_rd(bad, mk_exp(dat, 8'h10, '0, syn, "R7"));
    #1;
    chk("R7", "corrected before edge", PW'(rd_corr_o), '0);

    // R5: spare check bit at position 146
    for (int ln = 0; ln < NL; ln += 5) begin
      bad = row;
      bad[row_bit(ln, CW)] = ~bad[row_bit(ln, CW)];
      syn = '0; syn[ln] = SW'(256);
      drive_rd(bad, mk_exp(dat, NL'(1) << ln, '0, syn, "R5"));
    end

    // R6: positions 3, 64, 128 flipped in lane 2 -> syndrome 195
    bad = row;
    bad[row_bit(2, 3)]   = ~bad[row_bit(2, 3)];
    bad[row_bit(2, 64)]  = ~bad[row_bit(2, 64)];
    bad[row_bit(2, 128)] = ~bad[row_bit(2, 128)];
    exd = dat; exd[2][0] = ~exd[2][0];
    syn = '0; syn[2] = SW'(195);
    drive_rd(bad, mk_exp(exd, '0, 8'h04, syn, "R6"));
    // R6: positions 145 and 146 in lane 6 -> syndrome 401
    bad = row;
    bad[row_bit(6, 145)] = ~bad[row_bit(6, 145)];
    bad[row_bit(6, 146)] = ~bad[row_bit(6, 146)];
    exd = dat; exd[6][DW-1] = ~exd[6][DW-1];
    syn = '0; syn[6] = SW'(401);
    drive_rd(bad, mk_exp(exd, '0, 8'h40, syn, "R6"));

    // R9: eight adjacent row bits (position 6 of every lane)
    bad = row;
    for (int b = 40; b < 48; b++) bad[b] = ~bad[b];
    for (int k = 0; k < NL; k++) syn[k] = SW'(6);
    drive_rd(bad, mk_exp(dat, '1, '0, syn, "R9"));
    // R9: different positions in every lane at once
    bad = row;
    for (int k = 0; k < NL; k++) begin
      bad[row_bit(k, 17 * k + 3)] = ~bad[row_bit(k, 17 * k + 3)];
      syn[k] = SW'(17 * k + 3);
    end
    drive_rd(bad, mk_exp(dat, '1, '0, syn, "R9"));

    @(negedge clk_i);
    @(negedge clk_i);
    chk("R3", "scoreboard drained", PW'(sb.size()), '0);
    finish_run();
  end
endmodule